// File: doc/BRIEF.md
# Microsecond Limit Timer

This block is a microsecond-resolution counter that runs from 1 up toward a programmable limit. When the next count would equal the limit, the counter drops back to 1 and a sticky interrupt flag is set. The flag drives the `irq` output. Software acknowledges it by reading the limit word, so the read itself clears the interrupt. A second address loads a new limit without restarting the count and without touching the flag. The system-wide instance uses one copy of the block, and each processor gets its own instance. The per-processor variant (`PER_CPU=1`) adds a control word that can freeze the counter.

The count and limit fields sit at bit 10 and upward in the 32-bit word. For a period of N microseconds, software writes the value (N+1) << 10. A prescaler, sized from the number of clock cycles per microsecond, produces one count step per microsecond. Word addresses are 0 for the limit, 1 for the count, 2 for the limit without side effects, and 3 for the run control.

Top module: `ltc_timer`

## Requirements
- R1: After reset the count reads 1, the limit reads 0, `irq` is low and the run-control word reads 0.
- R2: The count advances by exactly one every `CLK_PER_US` clock cycles. The first step comes `CLK_PER_US` cycles after a write to address 0.
- R3: With a limit L of 2 or more, the tick that would make the count equal L instead sets the count to 1 and sets the interrupt flag. The period is L-1 microseconds. A read of address 1 returns the count in bits 30:10, with every other bit 0.
- R4: The interrupt flag stays set across later ticks until a read with `rd_en` at address 0 clears it on that clock edge. The read returns the flag in bit 31 and the limit in bits 30:10.
- R5: A write to address 0 loads the limit from bits 30:10, sets the count to 1, clears the flag and restarts the prescaler.
- R6: A write to address 2 loads the limit from bits 30:10. It leaves the count, the prescaler and the interrupt flag unchanged.
- R7: With a limit of 0 the counter runs freely and never sets the interrupt flag.
- R8: Writing 1 to bit 0 of address 3 freezes the count and the prescaler. Writing 0 resumes counting from the held prescaler phase. Address 3 reads the stored bit in bit 0.
- R9: If an expiry and an acknowledging read happen on the same edge, the flag stays set. If a tick and a write to address 0 happen on the same edge, the write wins.
- R10: Writes to address 1 have no effect on the count or the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously inside the block |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe; only matters at address 0, where it acknowledges the interrupt |
| addr | input | 2 | Word address: 0 limit, 1 count, 2 limit without side effects, 3 run control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`; combinational |
| irq | output | 1 | Latched interrupt request |

## Verification
Two pairs of events can land on the same clock edge. An expiry can meet the acknowledging read of address 0, and a prescaler tick can meet a write to address 0. The bench tracks the microsecond phase from the last restart. It then issues the read exactly in the cycle before the expiry edge and expects `irq` to remain high afterwards. It also issues a limit write exactly on a tick edge and expects the count to read 1 instead of advancing. Randomly chosen periods and sample points are checked against count values computed from elapsed cycles.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  localparam int LTC_SHIFT = 10;
  localparam int LTC_DW    = 32;

  typedef enum logic [1:0] {
    REG_LIMIT    = 2'd0,
    REG_COUNT    = 2'd1,
    REG_LIMIT_NC = 2'd2,
    REG_RUNCTL   = 2'd3
  } ltc_reg_e;
endpackage

// File: rtl/ltc_reset_sync.sv
module ltc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/ltc_tick_gen.sv
module ltc_tick_gen #(
  parameter int CLK_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int PRE_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_END = PRE_W'(CLK_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_end;

  assign at_end = (pre_q == PRE_END);
  assign tick   = run && at_end;

  always_comb begin
    pre_d = pre_q;
    if (restart)     pre_d = '0;
    else if (run)    pre_d = at_end ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/ltc_count_core.sv
module ltc_count_core #(
  parameter int VAL_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             lim_wr,
  input  logic             lim_nc_wr,
  input  logic             ack,
  input  logic [VAL_W-1:0] wr_val,
  output logic [VAL_W-1:0] count,
  output logic [VAL_W-1:0] limit,
  output logic             irq,
  output logic             hit
);
  logic [VAL_W-1:0] cnt_q, cnt_d, lim_q, lim_d, cnt_inc;
  logic             irq_q, irq_d;

  assign cnt_inc = cnt_q + VAL_W'(1);
  assign hit     = tick && (lim_q != '0) && (cnt_inc == lim_q);

  always_comb begin
    cnt_d = cnt_q;
    if (lim_wr)          cnt_d = VAL_W'(1);
    else if (tick) begin
      if (hit || cnt_inc == '0) cnt_d = VAL_W'(1);
      else                      cnt_d = cnt_inc;
    end
  end

  always_comb begin
    lim_d = lim_q;
    if (lim_wr || lim_nc_wr) lim_d = wr_val;
  end

  always_comb begin
    irq_d = irq_q;
    if (lim_wr)     irq_d = 1'b0;
    else if (hit)   irq_d = 1'b1;
    else if (ack)   irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= VAL_W'(1);
      lim_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
      irq_q <= irq_d;
    end
  end

  assign count = cnt_q;
  assign limit = lim_q;
  assign irq   = irq_q;
endmodule

// File: rtl/ltc_regs.sv
module ltc_regs #(
  parameter int VAL_W   = 21,
  parameter bit PER_CPU = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [31:0]      wdata,
  input  logic [VAL_W-1:0] count,
  input  logic [VAL_W-1:0] limit,
  input  logic             irq,
  output logic             lim_wr,
  output logic             lim_nc_wr,
  output logic             ack,
  output logic [VAL_W-1:0] wr_val,
  output logic             stop,
  output logic [31:0]      rdata
);
  import ltc_pkg::*;

  localparam logic [31:0] FIELD_MASK = ((32'h1 << VAL_W) - 32'h1) << LTC_SHIFT;
  localparam logic [31:0] USED_MASK  = FIELD_MASK | (PER_CPU ? 32'h1 : 32'h0);

  ltc_reg_e sel;
  logic [30:0] lim_sh, cnt_sh;
  logic        unused_wdata;

  assign sel          = ltc_reg_e'(addr);
  assign lim_wr       = wr_en && (sel == REG_LIMIT);
  assign lim_nc_wr    = wr_en && (sel == REG_LIMIT_NC);
  assign ack          = rd_en && (sel == REG_LIMIT);
  assign wr_val       = wdata[LTC_SHIFT +: VAL_W];
  assign unused_wdata = ^(wdata & ~USED_MASK);

  generate
    if (PER_CPU) begin : g_runctl
      logic stop_q, stop_d;
      always_comb begin
        stop_d = stop_q;
        if (wr_en && sel == REG_RUNCTL) stop_d = wdata[0];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stop_q <= 1'b0;
        else        stop_q <= stop_d;
      end
      assign stop = stop_q;
    end else begin : g_no_runctl
      assign stop = 1'b0;
    end
  endgenerate

  assign lim_sh = 31'(limit) << LTC_SHIFT;
  assign cnt_sh = 31'(count) << LTC_SHIFT;

  always_comb begin
    unique case (sel)
      REG_LIMIT, REG_LIMIT_NC: rdata = {irq, lim_sh};
      REG_COUNT:               rdata = {1'b0, cnt_sh};
      default:                 rdata = {31'b0, stop};
    endcase
  end
endmodule

// File: rtl/ltc_timer.sv
module ltc_timer #(
  parameter int CLK_PER_US = 100,
  parameter int VAL_W      = 21,
  parameter bit PER_CPU    = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [1:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  logic             rst_sync_n;
  logic             tick, hit, stop, lim_wr, lim_nc_wr, ack;
  logic [VAL_W-1:0] count, limit, wr_val;

  ltc_reset_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  ltc_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_sync_n), .restart(lim_wr), .run(!stop), .tick(tick)
  );

  ltc_count_core #(.VAL_W(VAL_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .lim_wr(lim_wr),
    .lim_nc_wr(lim_nc_wr), .ack(ack), .wr_val(wr_val), .count(count),
    .limit(limit), .irq(irq), .hit(hit)
  );

  ltc_regs #(.VAL_W(VAL_W), .PER_CPU(PER_CPU)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(count), .limit(limit), .irq(irq), .lim_wr(lim_wr),
    .lim_nc_wr(lim_nc_wr), .ack(ack), .wr_val(wr_val), .stop(stop),
    .rdata(rdata)
  );
endmodule

// File: rtl/ltc_timer_chk.sv
module ltc_timer_chk #(
  parameter int VAL_W = 21
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             rd_en,
  input logic [1:0]       addr,
  input logic             irq,
  input logic [VAL_W-1:0] count,
  input logic [VAL_W-1:0] limit,
  input logic             stop,
  input logic             hit
);
  logic lim_w, nc_w, rd_l;
  assign lim_w = wr_en && addr == 2'd0;
  assign nc_w  = wr_en && addr == 2'd2;
  assign rd_l  = rd_en && addr == 2'd0;

  AST_LIMIT_WR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    lim_w |=> (!irq && count == VAL_W'(1)));                       // R5
  AST_NC_WR_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (nc_w && irq) |=> irq);                                        // R6
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !lim_w && !rd_l) |=> irq);                             // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_l && !hit) |=> !irq);                                      // R4
  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !lim_w) |=> (irq && count == VAL_W'(1)));              // R9
  AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (limit == '0 && !irq && !lim_w && !nc_w) |=> !irq);            // R7
  AST_STOP_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !lim_w) |=> $stable(count));                          // R8
  AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    count != '0);                                                  // R3
endmodule

bind ltc_timer ltc_timer_chk #(.VAL_W(VAL_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .irq(irq), .count(count), .limit(limit), .stop(stop), .hit(hit)
);

// File: tb/ltc_timer_test.sv
module ltc_timer_test;
  localparam int CPU = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ltc_timer #(.CLK_PER_US(CPU), .VAL_W(21), .PER_CPU(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  function automatic logic [31:0] f_cnt(int v);
    return 32'(v) << 10;
  endfunction
  function automatic logic [31:0] f_lim(bit flag, int v);
    return {flag, 31'(v) << 10};
  endfunction
  function automatic int f_exp_count(int m, int n);
    return 1 + ((m / CPU) % n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b0; #1; d = rdata;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1; #1; d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c0;
    void'($urandom(32'd1234));
    cyc(3); rst_n = 1'b1; cyc(4);

    // R1 reset state
    peek(2'd1, d); check("R1 count", d, f_cnt(1));
    peek(2'd0, d); check("R1 limit", d, f_lim(0, 0));
    peek(2'd3, d); check("R1 runctl", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R2/R3 period of 3 us
    wr(2'd0, f_cnt(4));
    peek(2'd1, d); check("R5 count after write", d, f_cnt(1));
    cyc(99);  peek(2'd1, d); check("R2 before tick", d, f_cnt(1));
    cyc(1);   peek(2'd1, d); check("R2 first tick", d, f_cnt(2));
    cyc(199); check("R3 irq before expiry", {31'b0, irq}, 32'h0);
    cyc(1);   check("R3 irq at expiry", {31'b0, irq}, 32'h1);
    peek(2'd1, d); check("R3 count wraps", d, f_cnt(1));
    // R4 sticky then acknowledged
    cyc(150); check("R4 irq held", {31'b0, irq}, 32'h1);
    rd(2'd0, d); check("R4 limit readback", d, f_lim(1, 4));
    check("R4 irq cleared by read", {31'b0, irq}, 32'h0);
    // R9 read on expiry edge (now m=451, expiry at 600)
    cyc(148); rd(2'd0, d); check("R9 read before expiry", d, f_lim(0, 4));
    check("R9 expiry beats ack", {31'b0, irq}, 32'h1);
    rd(2'd0, d); check("R4 second read", d, f_lim(1, 4));
    check("R4 irq cleared", {31'b0, irq}, 32'h0);
    // R9 limit write on a tick edge (m=601, tick at 700)
    cyc(98); wr(2'd0, f_cnt(6));
    peek(2'd1, d); check("R9 write beats tick", d, f_cnt(1));
    check("R5 irq low", {31'b0, irq}, 32'h0);
    cyc(100); peek(2'd1, d); check("R5 prescaler restarted", d, f_cnt(2));
    // R6 limit without side effects (m=100)
    cyc(150); wr(2'd2, f_cnt(20));
    peek(2'd1, d); check("R6 count kept", d, f_cnt(3));
    peek(2'd2, d); check("R6 limit loaded", d, f_lim(0, 20));
    cyc(1648); check("R6 irq before new limit", {31'b0, irq}, 32'h0);
    cyc(1);    check("R6 irq at new limit", {31'b0, irq}, 32'h1);
    wr(2'd2, f_cnt(20)); check("R6 irq kept by alias write", {31'b0, irq}, 32'h1);
    rd(2'd0, d); check("R4 clear", {31'b0, irq}, 32'h0);

    // R7 free run, R10 count write ignored
    wr(2'd0, 32'h0);
    wr(2'd1, 32'hFFFF_FC00);
    peek(2'd1, d); check("R10 count write ignored", d, f_cnt(1));
    cyc(2999); peek(2'd1, d); check("R7 free count", d, f_cnt(31));
    check("R7 no irq", {31'b0, irq}, 32'h0);

    // R8 freeze and resume
    wr(2'd3, 32'h1);
    peek(2'd3, d); check("R8 runctl readback", d, 32'h1);
    peek(2'd1, c0);
    cyc(500); peek(2'd1, d); check("R8 frozen", d, c0);
    wr(2'd3, 32'h0);
    cyc(200); peek(2'd1, d); check("R8 resumed", d, c0 + f_cnt(2));

    // R2/R3/R4 random periods
    for (int i = 0; i < 8; i++) begin
      int n, r;
      n = 2 + int'($urandom % 10);
      r = int'($urandom % (CPU * n - 1));
      wr(2'd0, f_cnt(n + 1));
      cyc(r); peek(2'd1, d); check("R2 random count", d, f_cnt(f_exp_count(r, n)));
      check("R3 random no early irq", {31'b0, irq}, 32'h0);
      cyc(CPU * n - r); check("R3 random expiry", {31'b0, irq}, 32'h1);
      peek(2'd1, d); check("R3 random wrap", d, f_cnt(1));
      rd(2'd0, d); check("R4 random readback", d, f_lim(1, n + 1));
      check("R4 random clear", {31'b0, irq}, 32'h0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule